// File: doc/BRIEF.md
# CAN Controller Register Access Guard

This block sits between a bus port and the register and message-buffer storage of a CAN controller. Each access brings an address, a direction, write data, a privilege flag and a test-access qualifier. The block checks the access against a fixed address map and against the current configuration: the highest active buffer index, the enable bit for the per-buffer mask registers, and the freeze-mode flag. It then either performs the access or ends it with a coded access error.

Storage is modelled by one small word RAM per mapped region. The regions are control registers, buffer space, mask space and test registers. The active buffer count sets where real buffers end and spare space begins. Spare space still works as general-purpose RAM, and the response flags when a legal access lands there.

The request side is a valid/ready interface. `req_ready` is held high, so the block never applies back-pressure and takes one access in every cycle that `req_valid` is high. The response side has no ready. Every accepted access yields exactly one single-cycle `rsp_valid` pulse on the next clock, and the consumer must take it in that cycle.

Top module: `acc_guard`

## Requirements
- R1: Every cycle with `req_valid` high produces `rsp_valid` high on the following clock, for exactly one cycle per access; back-to-back accesses give back-to-back responses; `req_ready` is always 1; when `rsp_valid` is low, `rsp_code`, `rsp_spare` and `rsp_rdata` are 0, and a write response carries `rsp_rdata` = 0.
- R2: Mapped regions are word-aligned byte offsets: control 0x000–0x02F, buffers 0x080 up to 0x080+16·NUM_MB−1, masks 0x880 up to 0x880+4·NUM_MB−1, test 0xA00–0xA1F; any other offset, or any offset with bits [1:0] non-zero, ends with `rsp_code` = 1 (unmapped).
- R3: The 32 bytes 0x060–0x07F directly below the first buffer are reserved and give code 1 for reads and writes.
- R4: A test-region access without `req_test_ok` gives code 2.
- R5: With `req_user` = 1, an access to the control, mask or test region gives code 3; the buffer region is open to user accesses.
- R6: A mask-region access with `cfg_mask_en` = 0 gives code 4.
- R7: A mask-region access with `cfg_mask_en` = 1 but `cfg_freeze` = 0 gives code 5, also in mask slots above the active buffers.
- R8: Exactly one code is reported per access. The checks run in this order: unmapped (1), test qualifier (2), privilege (3), mask enable (4), freeze (5). Code 0 means success.
- R9: An access that errors changes no storage, and an erroring read returns `rsp_rdata` = 0.
- R10: A legal write stores the data, and a later legal read of the same offset returns it in every region.
- R11: `rsp_spare` is 1 only for a successful access whose buffer index, (offset−0x080)/16 in buffer space or (offset−0x880)/4 in mask space, exceeds `cfg_maxmb`; such spare space reads and writes like RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_ready | output | 1 | Always 1, no back-pressure |
| req_addr | input | 12 | Byte offset of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_test_ok | input | 1 | Test-access qualifier |
| cfg_maxmb | input | 5 | Highest active buffer index |
| cfg_mask_en | input | 1 | Enables the per-buffer mask region |
| cfg_freeze | input | 1 | Freeze mode active |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_code | output | 3 | 0 ok, 1 unmapped, 2 test, 3 privilege, 4 mask disabled, 5 not frozen |
| rsp_spare | output | 1 | Legal access hit spare buffer or mask space |
| rsp_rdata | output | 32 | Read data, 0 on error or write |

## Verification
The bench moves `cfg_maxmb` between 0, 3 and 31 and checks offsets at the buffer/spare boundary. A boundary off by one buffer would misreport `rsp_spare` at 0x0C0 or 0x090. It stacks several faults on one access to pin down the priority; a reordered chain would report privilege where the test qualifier or the unmapped code should win. It issues erroring writes to the control, mask and test regions and then reads the same words back legally. A guard that gated only the response and not the write enable would return the overwritten data. The reserved gap below the buffers, the last mask slot and the first offsets past each region are also probed, where a loose range compare would accept the access.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam int CTRL_WORDS = 12;
  localparam int RSV_LO     = 'h060;
  localparam int MB_LO      = 'h080;
  localparam int MB_STRIDE  = 16;
  localparam int MASK_LO    = 'h880;
  localparam int TEST_LO    = 'hA00;
  localparam int TEST_WORDS = 8;
  localparam int NREG       = 4;

  typedef enum logic [2:0] {
    RC_OK = 3'd0, RC_UNMAPPED = 3'd1, RC_TEST = 3'd2,
    RC_PRIV = 3'd3, RC_MASKOFF = 3'd4, RC_NOFRZ = 3'd5
  } rc_e;

  typedef enum logic [1:0] {RG_CTRL = 2'd0, RG_MB = 2'd1, RG_MASK = 2'd2, RG_TEST = 2'd3} rg_e;

  function automatic int region_words(input int rg, input int nmb);
    case (rg)
      0:       return CTRL_WORDS;
      1:       return nmb * (MB_STRIDE / 4);
      2:       return nmb;
      default: return TEST_WORDS;
    endcase
  endfunction
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
#(
  parameter int NUM_MB = 32,
  localparam int MBI_W = $clog2(NUM_MB),
  localparam int IDX_W = $clog2(NUM_MB * (MB_STRIDE / 4))
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              user,
  input  logic              test_ok,
  input  logic              mask_en,
  input  logic              freeze,
  input  logic [MBI_W-1:0]  maxmb,
  output rg_e               region,
  output logic [IDX_W-1:0]  idx,
  output rc_e               code,
  output logic              spare
);
  localparam int MB_HI   = MB_LO + NUM_MB * MB_STRIDE;
  localparam int MASK_HI = MASK_LO + NUM_MB * 4;
  localparam int TEST_HI = TEST_LO + TEST_WORDS * 4;

  logic [ADDR_W-1:0] mb_off, mk_off, ct_off, ts_off;
  logic mapped, need_test, need_sup, is_mask, spare_raw;
  int   top_buf;

  always_comb begin
    top_buf   = (int'(maxmb) > NUM_MB - 1) ? NUM_MB - 1 : int'(maxmb);
    mb_off    = addr - ADDR_W'(MB_LO);
    mk_off    = addr - ADDR_W'(MASK_LO);
    ts_off    = addr - ADDR_W'(TEST_LO);
    ct_off    = addr;
    mapped    = 1'b0;
    need_test = 1'b0;
    need_sup  = 1'b0;
    is_mask   = 1'b0;
    spare_raw = 1'b0;
    region    = RG_CTRL;
    idx       = '0;
    if (addr[1:0] == 2'b00) begin
      if (int'(addr) < CTRL_WORDS * 4) begin
        mapped = 1'b1; need_sup = 1'b1; region = RG_CTRL;
        idx = IDX_W'(ct_off >> 2);
      end else if (int'(addr) >= MB_LO && int'(addr) < MB_HI) begin
        mapped = 1'b1; region = RG_MB;
        idx = IDX_W'(mb_off >> 2);
        spare_raw = int'(mb_off >> 4) > top_buf;
      end else if (int'(addr) >= MASK_LO && int'(addr) < MASK_HI) begin
        mapped = 1'b1; need_sup = 1'b1; is_mask = 1'b1; region = RG_MASK;
        idx = IDX_W'(mk_off >> 2);
        spare_raw = int'(mk_off >> 2) > top_buf;
      end else if (int'(addr) >= TEST_LO && int'(addr) < TEST_HI) begin
        mapped = 1'b1; need_sup = 1'b1; need_test = 1'b1; region = RG_TEST;
        idx = IDX_W'(ts_off >> 2);
      end
    end

    if (!mapped)                  code = RC_UNMAPPED;
    else if (need_test && !test_ok) code = RC_TEST;
    else if (need_sup && user)    code = RC_PRIV;
    else if (is_mask && !mask_en) code = RC_MASKOFF;
    else if (is_mask && !freeze)  code = RC_NOFRZ;
    else                          code = RC_OK;

    spare = (code == RC_OK) && spare_raw;
  end
endmodule

// File: rtl/acc_wordram.sv
module acc_wordram #(
  parameter int DEPTH = 16,
  parameter int AW    = 7,
  parameter int DW    = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic          in_range;

  assign in_range = int'(addr) < DEPTH;
  assign rdata    = in_range ? mem[addr[IW-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && in_range) begin
      mem[addr[IW-1:0]] <= wdata;
    end
  end
endmodule

// File: rtl/acc_guard.sv
module acc_guard
  import acc_pkg::*;
#(
  parameter int NUM_MB = 32,
  localparam int MBI_W = $clog2(NUM_MB),
  localparam int IDX_W = $clog2(NUM_MB * (MB_STRIDE / 4))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_user,
  input  logic              req_test_ok,
  input  logic [MBI_W-1:0]  cfg_maxmb,
  input  logic              cfg_mask_en,
  input  logic              cfg_freeze,
  output logic              rsp_valid,
  output logic [2:0]        rsp_code,
  output logic              rsp_spare,
  output logic [DATA_W-1:0] rsp_rdata
);
  rg_e              dec_region;
  rc_e              dec_code;
  logic [IDX_W-1:0] dec_idx;
  logic             dec_spare;
  logic [NREG-1:0]  we_vec;
  logic [NREG-1:0][DATA_W-1:0] rd_bus;

  assign req_ready = 1'b1;

  acc_decode #(.NUM_MB(NUM_MB)) u_dec (
    .addr(req_addr), .user(req_user), .test_ok(req_test_ok),
    .mask_en(cfg_mask_en), .freeze(cfg_freeze), .maxmb(cfg_maxmb),
    .region(dec_region), .idx(dec_idx), .code(dec_code), .spare(dec_spare)
  );

  always_comb begin
    for (int g = 0; g < NREG; g++)
      we_vec[g] = req_valid && req_write && (dec_code == RC_OK) && (int'(dec_region) == g);
  end

  for (genvar g = 0; g < NREG; g++) begin : g_ram
    localparam int DEPTH = region_words(g, NUM_MB);
    acc_wordram #(.DEPTH(DEPTH), .AW(IDX_W), .DW(DATA_W)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(we_vec[g]), .addr(dec_idx),
      .wdata(req_wdata), .rdata(rd_bus[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= 3'd0;
      rsp_spare <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_code  <= req_valid ? dec_code : RC_OK;
      rsp_spare <= req_valid && dec_spare;
      rsp_rdata <= (req_valid && !req_write && dec_code == RC_OK) ? rd_bus[dec_region] : '0;
    end
  end
endmodule

// File: rtl/acc_guard_chk.sv
module acc_guard_chk
  import acc_pkg::*;
#(
  parameter int NUM_MB = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_user,
  input logic              cfg_mask_en,
  input logic              rsp_valid,
  input logic [2:0]        rsp_code,
  input logic              rsp_spare,
  input logic [DATA_W-1:0] rsp_rdata
);
  localparam int MASK_HI = MASK_LO + NUM_MB * 4;

  logic in_rsv, in_mask, misal;
  assign in_rsv  = int'(req_addr) >= RSV_LO && int'(req_addr) < MB_LO;
  assign in_mask = int'(req_addr) >= MASK_LO && int'(req_addr) < MASK_HI && req_addr[1:0] == 2'b00;
  assign misal   = req_addr[1:0] != 2'b00;

  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_code == 3'd0 && !rsp_spare && rsp_rdata == '0));
  p_misaligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && misal) |=> rsp_code == 3'd1);
  p_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_rsv) |=> rsp_code == 3'd1);
  p_user_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_mask && req_user) |=> rsp_code == 3'd3);
  p_mask_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_mask && !req_user && !cfg_mask_en) |=> rsp_code == 3'd4);
  p_code_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_code <= 3'd5);
  p_err_rd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 3'd0) |-> rsp_rdata == '0);
  p_spare_ok_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_spare |-> (rsp_valid && rsp_code == 3'd0));
endmodule

bind acc_guard acc_guard_chk #(.NUM_MB(NUM_MB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_user(req_user), .cfg_mask_en(cfg_mask_en), .rsp_valid(rsp_valid),
  .rsp_code(rsp_code), .rsp_spare(rsp_spare), .rsp_rdata(rsp_rdata)
);

// File: tb/tb_acc_guard.sv
`timescale 1ns/1ps
module tb_acc_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [11:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        req_user = 1'b0, req_test_ok = 1'b0;
  logic [4:0]  cfg_maxmb = '0;
  logic        cfg_mask_en = 1'b0, cfg_freeze = 1'b0;
  logic        rsp_valid, rsp_spare;
  logic [2:0]  rsp_code;
  logic [31:0] rsp_rdata;

  logic        r_valid, r_spare;
  logic [2:0]  r_code;
  logic [31:0] r_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  acc_guard dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [11:0] a, input logic wr, input logic [31:0] wd,
                     input logic usr, input logic tok);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd;
    req_user = usr; req_test_ok = tok;
    @(negedge clk);
    req_valid = 1'b0;
    r_valid = rsp_valid; r_code = rsp_code; r_spare = rsp_spare; r_data = rsp_rdata;
  endtask

  task automatic cfg(input logic [4:0] mx, input logic men, input logic frz);
    @(negedge clk);
    cfg_maxmb = mx; cfg_mask_en = men; cfg_freeze = frz;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset valid", 32'(rsp_valid), 0);
    chk("R1 reset code", 32'(rsp_code), 0);
    chk("R1 ready", 32'(req_ready), 1);
  endtask

  task automatic t_ctrl;
    acc(12'h004, 1, 32'hA5A5_0004, 0, 0);
    chk("R1 write valid", 32'(r_valid), 1);
    chk("R1 write rdata", r_data, 0);
    acc(12'h02C, 1, 32'h1234_002C, 0, 0);
    acc(12'h004, 0, 0, 0, 0);
    chk("R10 ctrl code", 32'(r_code), 0);
    chk("R10 ctrl data", r_data, 32'hA5A5_0004);
    chk("R11 ctrl spare", 32'(r_spare), 0);
    acc(12'h02C, 0, 0, 0, 0);
    chk("R10 ctrl last", r_data, 32'h1234_002C);
    acc(12'h030, 0, 0, 0, 0);
    chk("R2 past ctrl", 32'(r_code), 1);
  endtask

  task automatic t_mb_spare;
    cfg(5'd0, 0, 0);
    acc(12'h080, 1, 32'h0000_0080, 1, 0);
    chk("R11 active spare", 32'(r_spare), 0);
    chk("R5 user mb", 32'(r_code), 0);
    acc(12'h090, 1, 32'h0000_0090, 0, 0);
    chk("R11 spare write", 32'(r_spare), 1);
    acc(12'h27C, 1, 32'h0000_027C, 0, 0);
    acc(12'h090, 0, 0, 0, 0);
    chk("R11 spare read", r_data, 32'h0000_0090);
    chk("R11 spare flag", 32'(r_spare), 1);
    acc(12'h280, 0, 0, 0, 0);
    chk("R2 past mb", 32'(r_code), 1);
    cfg(5'd31, 0, 0);
    acc(12'h27C, 0, 0, 0, 0);
    chk("R11 full spare", 32'(r_spare), 0);
    chk("R10 mb data", r_data, 32'h0000_027C);
    cfg(5'd3, 0, 0);
    acc(12'h0BC, 0, 0, 0, 0);
    chk("R11 idx3 spare", 32'(r_spare), 0);
    acc(12'h0C0, 0, 0, 0, 0);
    chk("R11 idx4 spare", 32'(r_spare), 1);
  endtask

  task automatic t_reserved;
    acc(12'h060, 0, 0, 0, 0);
    chk("R3 rsv lo", 32'(r_code), 1);
    acc(12'h07C, 0, 0, 0, 0);
    chk("R3 rsv hi", 32'(r_code), 1);
    acc(12'h064, 1, 32'hFFFF_FFFF, 0, 0);
    chk("R3 rsv write", 32'(r_code), 1);
    acc(12'h05C, 0, 0, 0, 0);
    chk("R2 gap", 32'(r_code), 1);
    acc(12'h086, 0, 0, 0, 0);
    chk("R2 misaligned", 32'(r_code), 1);
  endtask

  task automatic t_test;
    acc(12'hA04, 1, 32'h7E57_0004, 0, 1);
    chk("R4 qual write", 32'(r_code), 0);
    acc(12'hA04, 0, 0, 0, 0);
    chk("R4 no qual", 32'(r_code), 2);
    chk("R9 err rdata", r_data, 0);
    acc(12'hA04, 0, 0, 0, 1);
    chk("R10 test data", r_data, 32'h7E57_0004);
    acc(12'hA20, 0, 0, 0, 1);
    chk("R2 past test", 32'(r_code), 1);
  endtask

  task automatic t_priv;
    acc(12'h004, 0, 0, 1, 0);
    chk("R5 user ctrl", 32'(r_code), 3);
    acc(12'hA04, 0, 0, 1, 1);
    chk("R5 user test", 32'(r_code), 3);
    acc(12'h100, 1, 32'h0000_0100, 1, 0);
    chk("R5 user mb ok", 32'(r_code), 0);
  endtask

  task automatic t_mask;
    cfg(5'd0, 0, 1);
    acc(12'h880, 0, 0, 0, 0);
    chk("R6 mask off", 32'(r_code), 4);
    cfg(5'd0, 1, 0);
    acc(12'h880, 0, 0, 0, 0);
    chk("R7 no freeze", 32'(r_code), 5);
    acc(12'h8FC, 0, 0, 0, 0);
    chk("R7 spare no freeze", 32'(r_code), 5);
    cfg(5'd0, 1, 1);
    acc(12'h884, 1, 32'h0000_0884, 0, 0);
    chk("R11 mask spare", 32'(r_spare), 1);
    acc(12'h880, 1, 32'h0000_0880, 0, 0);
    chk("R11 mask active", 32'(r_spare), 0);
    acc(12'h884, 0, 0, 0, 0);
    chk("R10 mask data", r_data, 32'h0000_0884);
    acc(12'h900, 0, 0, 0, 0);
    chk("R2 past mask", 32'(r_code), 1);
  endtask

  task automatic t_priority;
    cfg(5'd0, 0, 0);
    acc(12'hA02, 0, 0, 1, 0);
    chk("R8 unmapped first", 32'(r_code), 1);
    acc(12'hA00, 0, 0, 1, 0);
    chk("R8 test before priv", 32'(r_code), 2);
    acc(12'h880, 0, 0, 1, 0);
    chk("R8 priv before mask", 32'(r_code), 3);
    acc(12'h880, 0, 0, 0, 0);
    chk("R8 enable before freeze", 32'(r_code), 4);
  endtask

  task automatic t_nowrite;
    acc(12'h004, 1, 32'hDEAD_BEEF, 1, 0);
    chk("R9 user write code", 32'(r_code), 3);
    acc(12'h004, 0, 0, 0, 0);
    chk("R9 ctrl kept", r_data, 32'hA5A5_0004);
    cfg(5'd0, 1, 0);
    acc(12'h884, 1, 32'hDEAD_0884, 0, 0);
    cfg(5'd0, 1, 1);
    acc(12'h884, 0, 0, 0, 0);
    chk("R9 mask kept", r_data, 32'h0000_0884);
    acc(12'hA04, 1, 32'hDEAD_0A04, 0, 0);
    acc(12'hA04, 0, 0, 0, 1);
    chk("R9 test kept", r_data, 32'h7E57_0004);
  endtask

  task automatic t_b2b;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 12'h004; req_user = 0; req_test_ok = 0;
    @(negedge clk);
    req_addr = 12'h02C;
    chk("R1 b2b first valid", 32'(rsp_valid), 1);
    chk("R1 b2b first data", rsp_rdata, 32'hA5A5_0004);
    @(negedge clk);
    req_valid = 0;
    chk("R1 b2b second valid", 32'(rsp_valid), 1);
    chk("R1 b2b second data", rsp_rdata, 32'h1234_002C);
    @(negedge clk);
    chk("R1 pulse ends", 32'(rsp_valid), 0);
    chk("R1 idle data", rsp_rdata, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_mb_spare();
    t_reserved();
    t_test();
    t_priv();
    t_mask();
    t_priority();
    t_nowrite();
    t_b2b();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule